// File: doc/BRIEF.md
# Serial Command Port Receiver

This block is the digital front end of a multi-channel converter's command port. A host drives a serial clock, a data line and an active-low frame strobe. All three are already synchronized into the system clock. The receiver collects command frames bit by bit. It can check an 8-bit CRC appended to each frame. It turns accepted frames into one-cycle write or read requests toward a parallel register bank.

When a read is requested, the selected register value is captured from the bank. It is then shifted out on the serial data output during the host's next frame. Usually that next frame is a command aimed at nothing. A CRC mismatch drives an active-low fault output and the frame is not executed. A programmable inactivity watchdog raises an active-high alert when no good frame has arrived for a set number of system clocks.

Each frame is 24 payload bits, sent most significant bit first:

| Bits | Field |
|------|-------|
| 23 | Read flag (1 = read, 0 = write) |
| 22:21 | Device select, compared with two static pins |
| 20:16 | Register number |
| 15:0 | Write data |

When the check mode pin is high, 8 CRC bits follow the payload, for 32 bits in all.

Top module: `cmdport_rx`

## Requirements
- R1: Data bits are taken only on falling edges of the serial clock seen while the frame strobe is low, most significant bit first. In the payload, bit 23 is the read flag (1 = read), bits 22:21 are the device select, bits 20:16 are the register number and bits 15:0 are the data.
- R2: A frame acts only if the number of falling edges at strobe release is exactly 24 with the check mode low, or exactly 32 with it high. Any other count produces no request and leaves the fault output unchanged.
- R3: In check mode, the last 8 bits must equal the CRC-8 with polynomial 0x07 and initial value 0, computed over the 24 payload bits most significant bit first. On a mismatch the frame issues no request and fault_n_o goes low.
- R4: fault_n_o returns high after any frame of legal length that passes its check.
- R5: An accepted write gives a single-cycle wr_req_o pulse, with reg_addr_o and wr_data_o taken from the frame. The pulse starts after the first clock edge that samples the strobe high following a low sample.
- R6: A frame whose device select differs from dev_addr_i issues no request.
- R7: An accepted read gives a single-cycle rd_req_o pulse, with the same timing as a write, and rd_data_i is sampled during that pulse. In the following frame, sdo_o carries the 24-bit word {000, register number, data}, most significant bit first. The first bit is valid from the strobe fall, and each later bit changes after a rising serial clock edge. Bits after the 24th are 0.
- R8: sdo_o is 0 during a frame that has no readback pending, such as a read request that follows a write.
- R9: alert_o rises once wdog_limit_i system clocks pass without a good frame. A limit of 0 stops the count. Only a frame of legal length that passes its check clears alert_o and restarts the count.
- R10: After reset, wr_req_o, rd_req_o, sdo_o and alert_o are 0 and fault_n_o is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, synchronized |
| fs_n_i | input | 1 | Active-low frame strobe, synchronized |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial readback data |
| dev_addr_i | input | 2 | Static device select |
| pec_en_i | input | 1 | CRC check mode (32-bit frames) |
| wdog_limit_i | input | WDOG_W | Watchdog timeout in clocks, 0 = off |
| wr_req_o | output | 1 | Write request pulse |
| rd_req_o | output | 1 | Read request pulse |
| reg_addr_o | output | 5 | Register number of the request |
| wr_data_o | output | 16 | Write data |
| rd_data_i | input | 16 | Register bank read data |
| alert_o | output | 1 | Inactivity alert |
| fault_n_o | output | 1 | Active-low CRC fault |

## Verification
A wrong bit count or a shifted payload shows up at the end of the same frame. Either no request is issued, or the register number and data it carries are wrong. A wrong latched readback word shows up one frame later, in the bits the host collects from sdo_o. A wrong CRC or a wrong watchdog state shows up within a frame or a timeout period, as a fault or alert level that disagrees with the frames sent so far.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int unsigned PAYLOAD_W = 24;
  localparam int unsigned CRC_W     = 8;
  localparam int unsigned DEV_AW    = 2;
  localparam int unsigned REG_AW    = 5;
  localparam int unsigned DATA_W    = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;

  typedef struct packed {
    logic              rd;
    logic [DEV_AW-1:0] dev;
    logic [REG_AW-1:0] reg_a;
    logic [DATA_W-1:0] data;
  } cmd_t;
endpackage

// File: rtl/sfr_crc8.sv
module sfr_crc8
  import sfr_pkg::*;
#(
  parameter int unsigned W = 24
) (
  input  logic [W-1:0]     data_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] stage [W+1];

  assign stage[0] = '0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic fb;
    assign fb = stage[i][CRC_W-1] ^ data_i[W-1-i];
    assign stage[i+1] = {stage[i][CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  end

  assign crc_o = stage[W];
endmodule

// File: rtl/sfr_shift_in.sv
module sfr_shift_in #(
  parameter int unsigned SH_W  = 32,
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_i,
  input  logic             fs_n_i,
  input  logic             sdi_i,
  output logic             sclk_rise_o,
  output logic             fs_rise_o,
  output logic [SH_W-1:0]  shreg_o,
  output logic [CNT_W-1:0] bitcnt_o
);
  localparam logic [CNT_W-1:0] CNT_SAT = '1;

  logic             sclk_q, fs_q;
  logic             sclk_fall;
  logic [SH_W-1:0]  sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign sclk_fall   = sclk_q & ~sclk_i;
  assign sclk_rise_o = ~sclk_q & sclk_i;
  assign fs_rise_o   = ~fs_q & fs_n_i;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (fs_n_i) begin
      cnt_d = '0;
    end else if (sclk_fall) begin
      sh_d = {sh_q[SH_W-2:0], sdi_i};
      if (cnt_q != CNT_SAT) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b1;
      fs_q   <= 1'b1;
      sh_q   <= '0;
      cnt_q  <= '0;
    end else begin
      sclk_q <= sclk_i;
      fs_q   <= fs_n_i;
      cnt_q  <= cnt_d;
      if (sclk_fall) sh_q <= sh_d;
    end
  end

  assign shreg_o  = sh_q;
  assign bitcnt_o = cnt_q;
endmodule

// File: rtl/sfr_watchdog.sv
module sfr_watchdog #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             alert_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   cnt_inc;
  logic             al_q, al_d;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    al_d  = al_q;
    if (kick_i) begin
      cnt_d = '0;
      al_d  = 1'b0;
    end else if ((limit_i != '0) && !al_q) begin
      cnt_d = cnt_inc[CNT_W-1:0];
      if (cnt_inc >= {1'b0, limit_i}) al_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      al_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      al_q  <= al_d;
    end
  end

  assign alert_o = al_q;
endmodule

// File: rtl/cmdport_rx.sv
module cmdport_rx
  import sfr_pkg::*;
#(
  parameter int unsigned WDOG_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              fs_n_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  input  logic [DEV_AW-1:0] dev_addr_i,
  input  logic              pec_en_i,
  input  logic [WDOG_W-1:0] wdog_limit_i,
  output logic              wr_req_o,
  output logic              rd_req_o,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              alert_o,
  output logic              fault_n_o
);
  localparam int unsigned FRAME_LONG = PAYLOAD_W + CRC_W;
  localparam int unsigned CNT_W      = $clog2(FRAME_LONG) + 1;
  localparam int unsigned PAD_W      = PAYLOAD_W - REG_AW - DATA_W;
  localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(PAYLOAD_W);
  localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(FRAME_LONG);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  logic                  sclk_rise, fs_rise;
  logic [FRAME_LONG-1:0] shreg;
  logic [CNT_W-1:0]      bitcnt;

  sfr_shift_in #(.SH_W(FRAME_LONG), .CNT_W(CNT_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .sclk_i     (sclk_i),
    .fs_n_i     (fs_n_i),
    .sdi_i      (sdi_i),
    .sclk_rise_o(sclk_rise),
    .fs_rise_o  (fs_rise),
    .shreg_o    (shreg),
    .bitcnt_o   (bitcnt)
  );

  // frame decode at strobe release
  logic [PAYLOAD_W-1:0] payload;
  logic [CRC_W-1:0]     crc_calc;
  cmd_t                 cmd;
  logic                 len_ok, crc_match, frame_good, crc_bad, exec_w;

  assign payload = pec_en_i ? shreg[FRAME_LONG-1:CRC_W] : shreg[PAYLOAD_W-1:0];

  sfr_crc8 #(.W(PAYLOAD_W)) u_crc (
    .data_i(payload),
    .crc_o (crc_calc)
  );

  assign cmd        = cmd_t'(payload);
  assign len_ok     = pec_en_i ? (bitcnt == LEN_LONG) : (bitcnt == LEN_SHORT);
  assign crc_match  = (crc_calc == shreg[CRC_W-1:0]);
  assign frame_good = fs_rise & len_ok & (~pec_en_i | crc_match);
  assign crc_bad    = fs_rise & len_ok & pec_en_i & ~crc_match;
  assign exec_w     = frame_good & (cmd.dev == dev_addr_i);

  sfr_watchdog #(.CNT_W(WDOG_W)) u_wdog (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .kick_i (frame_good),
    .limit_i(wdog_limit_i),
    .alert_o(alert_o)
  );

  // request, fault and readback state
  logic                 wr_q, wr_d, rd_q, rd_d;
  logic [REG_AW-1:0]    addr_q, addr_d;
  logic [DATA_W-1:0]    data_q, data_d;
  logic                 perr_q, perr_d;
  logic [PAYLOAD_W-1:0] sdo_sh_q, sdo_sh_d, rb_word;
  logic                 sdo_vld_q, sdo_vld_d;

  assign rb_word = {{PAD_W{1'b0}}, addr_q, rd_data_i};

  always_comb begin
    wr_d   = exec_w & ~cmd.rd;
    rd_d   = exec_w & cmd.rd;
    addr_d = addr_q;
    data_d = data_q;
    if (exec_w) begin
      addr_d = cmd.reg_a;
      if (!cmd.rd) data_d = cmd.data;
    end

    perr_d = perr_q;
    if (crc_bad)         perr_d = 1'b1;
    else if (frame_good) perr_d = 1'b0;

    sdo_sh_d  = sdo_sh_q;
    sdo_vld_d = sdo_vld_q;
    if (rd_q) begin
      sdo_sh_d  = rb_word;
      sdo_vld_d = 1'b1;
    end else if (fs_rise) begin
      sdo_vld_d = 1'b0;
    end else if (sclk_rise && !fs_n_i && (bitcnt != '0)) begin
      sdo_sh_d = {sdo_sh_q[PAYLOAD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      wr_q      <= 1'b0;
      rd_q      <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
      perr_q    <= 1'b0;
      sdo_sh_q  <= '0;
      sdo_vld_q <= 1'b0;
    end else begin
      wr_q      <= wr_d;
      rd_q      <= rd_d;
      perr_q    <= perr_d;
      sdo_vld_q <= sdo_vld_d;
      if (exec_w) addr_q <= addr_d;
      if (exec_w) data_q <= data_d;
      sdo_sh_q  <= sdo_sh_d;
    end
  end

  assign wr_req_o   = wr_q;
  assign rd_req_o   = rd_q;
  assign reg_addr_o = addr_q;
  assign wr_data_o  = data_q;
  assign fault_n_o  = ~perr_q;
  assign sdo_o      = sdo_vld_q & sdo_sh_q[PAYLOAD_W-1];
endmodule

// File: rtl/cmdport_rx_chk.sv
module cmdport_rx_chk #(
  parameter int unsigned WDOG_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fs_n_i,
  input logic [WDOG_W-1:0] wdog_limit_i,
  input logic              wr_req_o,
  input logic              rd_req_o,
  input logic              alert_o,
  input logic              fault_n_o
);
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_req_o && rd_req_o)); // R5

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o |=> !wr_req_o); // R5

  AST_WR_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_req_o) |-> ($past(fs_n_i) && !$past(fs_n_i, 2))); // R5

  AST_RD_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req_o) |-> ($past(fs_n_i) && !$past(fs_n_i, 2))); // R7

  AST_FAULT_NO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_n_o) |-> (!wr_req_o && !rd_req_o)); // R3

  AST_ALERT_NEEDS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alert_o) |-> ($past(wdog_limit_i) != '0)); // R9

  AST_ALERT_CLEAR_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alert_o) |-> ($past(fs_n_i) && !$past(fs_n_i, 2))); // R9
endmodule

bind cmdport_rx cmdport_rx_chk #(.WDOG_W(WDOG_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fs_n_i      (fs_n_i),
  .wdog_limit_i(wdog_limit_i),
  .wr_req_o    (wr_req_o),
  .rd_req_o    (rd_req_o),
  .alert_o     (alert_o),
  .fault_n_o   (fault_n_o)
);

// File: tb/sim_cmdport_rx.sv
`timescale 1ns/1ps
module sim_cmdport_rx;
  localparam int unsigned WDOG_W = 20;
  localparam logic [1:0]  DEV    = 2'b10;
  // vector: [21] check mode, [20:16] register, [15:0] data
  localparam logic [21:0] VEC [8] = '{
    {1'b0, 5'd0,  16'hFFFF},
    {1'b1, 5'd31, 16'h0000},
    {1'b0, 5'd3,  16'h0F0F},
    {1'b1, 5'd17, 16'hA5A5},
    {1'b0, 5'd10, 16'h8001},
    {1'b1, 5'd22, 16'h7FFE},
    {1'b1, 5'd5,  16'h1234},
    {1'b0, 5'd30, 16'hC3C3}
  };

  logic clk = 1'b0;
  logic rst_n, sclk, fs_n, sdi, sdo, pec_en, wr_req, rd_req, alert, fault_n;
  logic [1:0]        dev;
  logic [WDOG_W-1:0] limit;
  logic [4:0]        reg_addr;
  logic [15:0]       wr_data, rd_data;
  logic [15:0]       bank [32];
  int nchk = 0, nfail = 0, wr_cnt = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  cmdport_rx #(.WDOG_W(WDOG_W)) u0 (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .fs_n_i(fs_n), .sdi_i(sdi),
    .sdo_o(sdo), .dev_addr_i(dev), .pec_en_i(pec_en), .wdog_limit_i(limit),
    .wr_req_o(wr_req), .rd_req_o(rd_req), .reg_addr_o(reg_addr),
    .wr_data_o(wr_data), .rd_data_i(rd_data), .alert_o(alert), .fault_n_o(fault_n)
  );

  assign rd_data = bank[reg_addr];

  always @(negedge clk) begin
    if (rst_n && wr_req) begin
      wr_cnt++;
      bank[reg_addr] = wr_data;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] crc8(input logic [23:0] d);
    logic [7:0] c;
    c = 8'h00;
    for (int i = 23; i >= 0; i--) begin
      logic fb;
      fb = c[7] ^ d[i];
      c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  function automatic logic [23:0] mk(input logic rd, input logic [1:0] d,
                                     input logic [4:0] a, input logic [15:0] v);
    return {rd, d, a, v};
  endfunction

  task automatic shift_frame(input int nbits, input logic [31:0] word, output logic [31:0] rx);
    rx = '0;
    @(negedge clk); fs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = nbits - 1; i >= 0; i--) begin
      sdi = word[i];
      repeat (4) @(negedge clk);
      rx = {rx[30:0], sdo};
      sclk = 1'b0;
      repeat (4) @(negedge clk);
      sclk = 1'b1;
    end
    repeat (4) @(negedge clk);
    fs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic frame(input logic pec, input logic [23:0] pl, input logic bad,
                       output logic [31:0] rx);
    pec_en = pec;
    if (pec) shift_frame(32, {pl, crc8(pl) ^ (bad ? 8'h01 : 8'h00)}, rx);
    else     shift_frame(24, {8'h00, pl}, rx);
  endtask

  logic [31:0] rx, rb;
  int w0;

  initial begin
    for (int i = 0; i < 32; i++) bank[i] = 16'h0000;
    rst_n = 1'b0; sclk = 1'b1; fs_n = 1'b1; sdi = 1'b0;
    dev = DEV; pec_en = 1'b0; limit = '0;
    repeat (5) @(negedge clk);
    check("R10 wr_req", {31'd0, wr_req}, 32'd0);
    check("R10 rd_req", {31'd0, rd_req}, 32'd0);
    check("R10 sdo", {31'd0, sdo}, 32'd0);
    check("R10 alert", {31'd0, alert}, 32'd0);
    check("R10 fault_n", {31'd0, fault_n}, 32'd1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // table walk: write, read request, readback during an unaddressed frame
    for (int v = 0; v < 8; v++) begin
      w0 = wr_cnt;
      frame(VEC[v][21], mk(1'b0, DEV, VEC[v][20:16], VEC[v][15:0]), 1'b0, rx);
      check("R5 write pulse count", wr_cnt, w0 + 1);
      check("R1 R5 stored data", {16'd0, bank[VEC[v][20:16]]}, {16'd0, VEC[v][15:0]});
      frame(VEC[v][21], mk(1'b1, DEV, VEC[v][20:16], 16'h0), 1'b0, rx);
      check("R8 sdo idle during read request", rx, 32'd0);
      w0 = wr_cnt;
      frame(VEC[v][21], mk(1'b0, ~DEV, 5'd0, 16'h0), 1'b0, rb);
      check("R6 foreign device ignored", wr_cnt, w0);
      if (VEC[v][21]) check("R7 readback 32-bit frame", rb, {3'b000, VEC[v][20:16], VEC[v][15:0], 8'h00});
      else            check("R7 readback 24-bit frame", rb, {8'h00, 3'b000, VEC[v][20:16], VEC[v][15:0]});
    end

    // R7: back-to-back reads, first result arrives in the second read frame
    frame(1'b0, mk(1'b1, DEV, 5'd0, 16'h0), 1'b0, rx);
    frame(1'b0, mk(1'b1, DEV, 5'd31, 16'h0), 1'b0, rx);
    check("R7 pipelined first read", rx, {8'h00, 3'b000, 5'd0, 16'hFFFF});
    frame(1'b0, mk(1'b0, ~DEV, 5'd0, 16'h0), 1'b0, rx);
    check("R7 pipelined second read", rx, {8'h00, 3'b000, 5'd31, 16'h0000});

    // R3: corrupted CRC is not executed and raises the fault
    w0 = wr_cnt;
    frame(1'b1, mk(1'b0, DEV, 5'd3, 16'h1234), 1'b1, rx);
    check("R3 bad CRC no write", wr_cnt, w0);
    check("R3 fault_n low", {31'd0, fault_n}, 32'd0);
    frame(1'b1, mk(1'b1, DEV, 5'd3, 16'h0), 1'b0, rx);
    check("R4 good frame clears fault", {31'd0, fault_n}, 32'd1);
    frame(1'b1, mk(1'b0, ~DEV, 5'd0, 16'h0), 1'b0, rx);
    check("R3 register kept old value", rx, {3'b000, 5'd3, 16'h0F0F, 8'h00});

    // R2: wrong bit counts are discarded, fault level unchanged
    frame(1'b1, mk(1'b0, DEV, 5'd3, 16'h1111), 1'b1, rx);
    w0 = wr_cnt;
    pec_en = 1'b0;
    shift_frame(23, {9'd0, mk(1'b0, DEV, 5'd3, 16'h2222) >> 1}, rx);
    shift_frame(25, {8'd0, 1'b0, mk(1'b0, DEV, 5'd3, 16'h3333)} , rx);
    shift_frame(32, {8'd0, mk(1'b0, DEV, 5'd3, 16'h4444)}, rx);
    check("R2 short/long frames no write", wr_cnt, w0);
    check("R2 fault unchanged", {31'd0, fault_n}, 32'd0);
    pec_en = 1'b1;
    shift_frame(24, {8'd0, mk(1'b0, DEV, 5'd3, 16'h5555)}, rx);
    check("R2 24 bits in check mode no write", wr_cnt, w0);
    check("R2 fault still low", {31'd0, fault_n}, 32'd0);
    frame(1'b0, mk(1'b0, ~DEV, 5'd0, 16'h0), 1'b0, rx);
    check("R4 fault released", {31'd0, fault_n}, 32'd1);

    // R9: inactivity watchdog
    limit = 20'd300;
    repeat (150) @(negedge clk);
    check("R9 alert not before limit", {31'd0, alert}, 32'd0);
    repeat (200) @(negedge clk);
    check("R9 alert after limit", {31'd0, alert}, 32'd1);
    frame(1'b1, mk(1'b0, DEV, 5'd7, 16'h0), 1'b1, rx);
    check("R9 bad frame keeps alert", {31'd0, alert}, 32'd1);
    frame(1'b1, mk(1'b0, ~DEV, 5'd0, 16'h0), 1'b0, rx);
    check("R9 good frame clears alert", {31'd0, alert}, 32'd0);
    limit = '0;
    repeat (1000) @(negedge clk);
    check("R9 limit zero never alerts", {31'd0, alert}, 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule